// File: doc/BRIEF.md
# Exact Run-Length Mealy Detector

This block watches a single serial bit stream. It raises its output when a run of consecutive 1s has just ended and that run was exactly two or exactly four bits long. A run is only known to have ended when the following 0 arrives. For that reason the output is a Mealy output: it is formed in the same cycle as that 0, from the stored run count and the live input, and it has no register stage.

The machine keeps six states: idle, then one, two, three and four 1s seen, and a saturated "more than four" state. A 0 in any state sends the machine back to idle. Reset is synchronous and active high. The serial input is one plain level per clock and has no handshake, because the output has to follow the present input level combinationally.

Top module: `exact_run_detector`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine goes to idle. In the following cycle `hit_out` is 0 for either value of `serial_in`.
- R2: `hit_out` is 1 while `serial_in` is 0 if exactly two 1s were sampled since the last 0 or the last reset.
- R3: `hit_out` is 1 while `serial_in` is 0 if exactly four 1s were sampled since the last 0 or the last reset.
- R4: A run of one or three 1s ended by a 0 leaves `hit_out` at 0.
- R5: A run of five or more 1s, of any length, ended by a 0 leaves `hit_out` at 0. The count saturates and does not wrap.
- R6: `hit_out` is 0 in every cycle in which `serial_in` is 1.
- R7: A sampled 0 returns the machine to idle, so the next run is counted from zero. With no 1s since the last 0, a 0 gives `hit_out` = 0.
- R8: `hit_out` follows every change of `serial_in` between clock edges in the same cycle, however many times the input changes.
- R9: A reset during a run discards the partial count. The sequence 1,1, then reset, then 0 gives `hit_out` = 0.
- R10: The input sequence 0110111011110111110, applied from reset, gives the output sequence 0001000000001000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial data bit, sampled at each rising edge |
| hit_out | output | 1 | Mealy flag: a run of exactly two or four 1s ends in this cycle |

## Verification
The bench builds the block with its only configuration: run lengths two and four, and a three-bit state code with saturation after four. From reset it applies every one of the 1024 ten-bit input words, each followed by a closing 0. This drives every state through every transition, including saturation after a long run. Each output is compared with a run-count model kept in the bench. Directed cases add reset in the middle of a run, repeated input toggling inside one cycle, and the given nineteen-bit sequence.

// File: rtl/runlen_pkg.sv
package runlen_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_ONE  = 3'd1,
    ST_TWO  = 3'd2,
    ST_THREE= 3'd3,
    ST_FOUR = 3'd4,
    ST_LONG = 3'd5
  } run_state_t;
endpackage

// File: rtl/runlen_next.sv
module runlen_next
  import runlen_pkg::*;
(
  input  run_state_t cur_st,
  input  logic       bit_i,
  output run_state_t nxt_st
);
  always_comb begin
    nxt_st = ST_IDLE;
    if (bit_i) begin
      unique case (cur_st)
        ST_IDLE:  nxt_st = ST_ONE;
        ST_ONE:   nxt_st = ST_TWO;
        ST_TWO:   nxt_st = ST_THREE;
        ST_THREE: nxt_st = ST_FOUR;
        ST_FOUR:  nxt_st = ST_LONG;
        ST_LONG:  nxt_st = ST_LONG;
        default:  nxt_st = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/runlen_state_reg.sv
module runlen_state_reg
  import runlen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  run_state_t d_st,
  output run_state_t q_st
);
  always_ff @(posedge clk) begin
    if (rst) q_st <= ST_IDLE;
    else     q_st <= d_st;
  end
endmodule

// File: rtl/runlen_out.sv
module runlen_out
  import runlen_pkg::*;
(
  input  run_state_t cur_st,
  input  logic       bit_i,
  output logic       hit_o
);
  logic exact_len;

  always_comb begin
    exact_len = (cur_st == ST_TWO) || (cur_st == ST_FOUR);
    hit_o     = exact_len && !bit_i;
  end
endmodule

// File: rtl/exact_run_detector.sv
module exact_run_detector
  import runlen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  output logic hit_out
);
  run_state_t state_q;
  run_state_t state_d;

  runlen_next u_next (
    .cur_st(state_q),
    .bit_i (serial_in),
    .nxt_st(state_d)
  );

  runlen_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d_st(state_d),
    .q_st(state_q)
  );

  runlen_out u_out (
    .cur_st(state_q),
    .bit_i (serial_in),
    .hit_o (hit_out)
  );
endmodule

// File: rtl/exact_run_detector_chk.sv
module exact_run_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       serial_in,
  input logic       hit_out,
  input logic [2:0] state_q
);
  // independent saturating run counter, 5 stands for "more than four"
  logic [2:0] ones_seen;

  always_ff @(posedge clk) begin
    if (rst)             ones_seen <= 3'd0;
    else if (!serial_in) ones_seen <= 3'd0;
    else if (ones_seen < 3'd5) ones_seen <= ones_seen + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit_out);

  assert_two_hits_R2: assert property (@(posedge clk) disable iff (rst)
    (!serial_in && ones_seen == 3'd2) |-> hit_out);

  assert_four_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (!serial_in && ones_seen == 3'd4) |-> hit_out);

  assert_odd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!serial_in && (ones_seen == 3'd1 || ones_seen == 3'd3)) |-> !hit_out);

  assert_long_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!serial_in && ones_seen == 3'd5) |-> !hit_out);

  assert_one_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    serial_in |-> !hit_out);

  assert_zero_idles_R7: assert property (@(posedge clk) disable iff (rst)
    !serial_in |=> (state_q == 3'd0));
endmodule

bind exact_run_detector exact_run_detector_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .serial_in(serial_in),
  .hit_out  (hit_out),
  .state_q  (state_q)
);

// File: tb/exact_run_detector_tb_top.sv
`timescale 1ns/1ps
module exact_run_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b0;
  logic hit_out;

  int n_tests = 0;
  int n_fail  = 0;
  int run_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  exact_run_detector dut_i (
    .clk      (clk),
    .rst      (rst),
    .serial_in(serial_in),
    .hit_out  (hit_out)
  );

  task automatic check(input string req, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hit_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // reset with input 0; returns 2 ns after the edge
  task automatic do_reset();
    rst = 1'b1;
    serial_in = 1'b0;
    @(posedge clk);
    #2;
    rst = 1'b0;
    run_cnt = 0;
  endtask

  // apply one bit, check the Mealy output, then advance the model at the edge
  task automatic step(input bit b, input string tag);
    bit exp;
    string req;
    serial_in = b;
    #1;
    exp = !b && (run_cnt == 2 || run_cnt == 4);
    if (tag != "") req = tag;
    else if (b) req = "R6";
    else if (run_cnt == 2) req = "R2";
    else if (run_cnt == 4) req = "R3";
    else if (run_cnt == 1 || run_cnt == 3) req = "R4";
    else if (run_cnt >= 5) req = "R5";
    else req = "R7";
    check(req, hit_out, exp);
    @(posedge clk);
    #2;
    run_cnt = b ? run_cnt + 1 : 0;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle after reset, both input values
    serial_in = 1'b0; #1; check("R1", hit_out, 1'b0);
    serial_in = 1'b1; #1; check("R1", hit_out, 1'b0);
    serial_in = 1'b0; #1;

    // R10: given sequence
    begin
      bit [18:0] seq_in  = 19'b0110111011110111110;
      bit [18:0] seq_out = 19'b0001000000001000000;
      do_reset();
      for (int i = 18; i >= 0; i--) begin
        serial_in = seq_in[i];
        #1;
        check("R10", hit_out, seq_out[i]);
        @(posedge clk);
        #2;
      end
    end

    // R9: reset mid-run discards the count
    do_reset();
    step(1'b1, "");
    step(1'b1, "");
    do_reset();
    step(1'b0, "R9");
    step(1'b1, "");
    do_reset();
    step(1'b1, "");
    step(1'b0, "R9");

    // R8: Mealy follow with state at two, toggling inside one cycle
    do_reset();
    step(1'b1, "");
    step(1'b1, "");
    for (int k = 0; k < 3; k++) begin
      serial_in = 1'b0; #1; check("R8", hit_out, 1'b1);
      serial_in = 1'b1; #1; check("R8", hit_out, 1'b0);
    end
    step(1'b0, "R8");

    // R5: very long run
    do_reset();
    for (int k = 0; k < 12; k++) step(1'b1, "");
    step(1'b0, "R5");

    // exhaustive sweep: all ten-bit words, closing 0
    for (int w = 0; w < 1024; w++) begin
      do_reset();
      for (int i = 9; i >= 0; i--) step(w[i], "");
      step(1'b0, "");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule